// File: doc/BRIEF.md
# Program-Check Trap Entry Unit

This unit sits at the retire point of an in-order core and judges each issued instruction before its effects become architectural. It raises a program-check trap in two cases. The first is an instruction of a privileged class issued while the machine is in user state. The second is an instruction the decoder could not recognise. On a trap it saves the address of the faulting instruction and the machine state. It then forces the machine state into a fixed supervisor configuration and steers fetch to the single program-check vector.

The unit owns the machine state register and the two save registers. An instruction that completes normally advances the next address by four. It may also load a new machine state through the normal write port. A privileged halt instruction stops the unit for good.

Machine state bits use big-endian numbering: architectural bit n is stored at physical index 63−n. The named bits are:

| Bit | Physical index |
|-----|----------------|
| SF = 0 | 63 |
| EE = 48 | 15 |
| PR = 49 | 14 |
| IR = 58 | 5 |
| DR = 59 | 4 |
| RI = 62 | 1 |
| LE = 63 | 0 |

The cause bits written into the saved copy are architectural bit 44 (illegal instruction, physical 19) and architectural bit 45 (privilege fault, physical 18).

Top module: `prog_trap_unit`

## Requirements
- R1: All outputs are registered and update on the clock edge that samples `insn_valid`. A trapping instruction sets `nia` to 0x700. A normally completing instruction sets `nia` to `cia + 4`. The halt instruction leaves `nia` unchanged.
- R2: On a trap, `srr0` receives `cia`. `srr1` receives the machine state value as it was before the trap rewrote it, with exactly one cause bit also set.
- R3: The cause bit set in `srr1` is physical bit 18 for a privilege fault and physical bit 19 for an illegal instruction. The cause bit is never set in `msr`.
- R4: On a trap, `msr` becomes its previous value with physical bits 63 (SF) and 0 (LE) set, and physical bits 15 (EE), 14 (PR), 5 (IR), 4 (DR) and 1 (RI) cleared. All other bits keep their values.
- R5: The privileged classes are `cls_attn`, `cls_msr_move` and `cls_int_return`. `cls_spr_move` is privileged only when `spr_num_hi` is 1.
- R6: A privileged instruction traps only when `msr` physical bit 14 (PR) is 1. When it traps, it has no other effect: the `msr_wr_en` write is dropped and a halt instruction does not halt. When PR is 0, the instruction completes normally.
- R7: The privilege check wins over the illegal check. A privileged, illegal instruction in user state is tagged with the privilege cause. The halt instruction in supervisor state halts even if `insn_illegal` is set.
- R8: A halt instruction in supervisor state sets `halted`, which stays set until reset. While `halted` is set, `insn_valid` is ignored: `nia`, `msr`, `srr0` and `srr1` hold their values and no trap is taken.
- R9: `trap_taken` is high for exactly the one cycle after each trapping instruction. It stays low for normally completing instructions and for idle cycles.
- R10: A normally completing instruction with `msr_wr_en` set loads `msr_wr_val` into `msr`. Cycles with `insn_valid` low change nothing.
- R11: After reset: `nia`, `srr0` and `srr1` are 0, `msr` equals `RESET_MSR` (0 by default), and `trap_taken` and `halted` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | An instruction is presented this cycle |
| cls_attn | input | 1 | Instruction is the halt (attention) instruction |
| cls_msr_move | input | 1 | Instruction reads or writes the machine state register |
| cls_int_return | input | 1 | Instruction is an interrupt return |
| cls_spr_move | input | 1 | Instruction moves to or from a special register |
| spr_num_hi | input | 1 | High bit of the special register number (instruction bit 20) |
| insn_illegal | input | 1 | Decoder could not recognise the instruction |
| cia | input | 64 | Address of the presented instruction |
| msr_wr_en | input | 1 | Normally completing instruction writes the machine state |
| msr_wr_val | input | 64 | Value to write into the machine state |
| nia | output | 64 | Next instruction address |
| msr | output | 64 | Machine state register |
| srr0 | output | 64 | Saved instruction address |
| srr1 | output | 64 | Saved machine state with cause bit |
| trap_taken | output | 1 | One-cycle pulse after a trap, for pipeline flush |
| halted | output | 1 | Sticky halt flag |

## Verification
Each privileged class is presented in user state and again in supervisor state. This separates the class decode from the PR gate. The special-register move is tried with the high number bit clear and set. The two cause tags are told apart by faults that are privileged only, illegal only, and both together. A long random run mixes normal writes that toggle PR, back-to-back traps and idle cycles, against a cycle-by-cycle reference model. The final halt phase shows that later instructions, including illegal ones, leave every register untouched.

// File: rtl/prog_trap_unit.sv
module prog_trap_unit #(
  parameter int XLEN = 64,
  parameter logic [XLEN-1:0] VECTOR = 'h700,
  parameter logic [XLEN-1:0] RESET_MSR = '0,
  parameter int ILL_CAUSE = 44,
  parameter int PRIV_CAUSE = 45
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_valid,
  input  logic            cls_attn,
  input  logic            cls_msr_move,
  input  logic            cls_int_return,
  input  logic            cls_spr_move,
  input  logic            spr_num_hi,
  input  logic            insn_illegal,
  input  logic [XLEN-1:0] cia,
  input  logic            msr_wr_en,
  input  logic [XLEN-1:0] msr_wr_val,
  output logic [XLEN-1:0] nia,
  output logic [XLEN-1:0] msr,
  output logic [XLEN-1:0] srr0,
  output logic [XLEN-1:0] srr1,
  output logic            trap_taken,
  output logic            halted
);
  localparam int B_SF   = XLEN - 1 - 0;
  localparam int B_EE   = XLEN - 1 - 48;
  localparam int B_PR   = XLEN - 1 - 49;
  localparam int B_IR   = XLEN - 1 - 58;
  localparam int B_DR   = XLEN - 1 - 59;
  localparam int B_RI   = XLEN - 1 - 62;
  localparam int B_LE   = XLEN - 1 - 63;
  localparam int B_ILL  = XLEN - 1 - ILL_CAUSE;
  localparam int B_PRIV = XLEN - 1 - PRIV_CAUSE;

  logic live, priv_class, priv_fault, ill_fault, take, halt_now, retire;
  logic [XLEN-1:0] msr_entry, srr1_next;

  assign live       = insn_valid & ~halted;
  assign priv_class = cls_attn | cls_msr_move | cls_int_return | (cls_spr_move & spr_num_hi);
  assign priv_fault = live & priv_class & msr[B_PR];
  assign halt_now   = live & ~priv_fault & cls_attn;
  assign ill_fault  = live & ~priv_fault & ~cls_attn & insn_illegal;
  assign take       = priv_fault | ill_fault;
  assign retire     = live & ~take & ~cls_attn;

  always_comb begin
    msr_entry       = msr;
    msr_entry[B_SF] = 1'b1;
    msr_entry[B_EE] = 1'b0;
    msr_entry[B_PR] = 1'b0;
    msr_entry[B_IR] = 1'b0;
    msr_entry[B_DR] = 1'b0;
    msr_entry[B_RI] = 1'b0;
    msr_entry[B_LE] = 1'b1;
    srr1_next       = msr;
    if (priv_fault) srr1_next[B_PRIV] = 1'b1;
    else            srr1_next[B_ILL]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nia        <= '0;
      msr        <= RESET_MSR;
      srr0       <= '0;
      srr1       <= '0;
      trap_taken <= 1'b0;
      halted     <= 1'b0;
    end else begin
      trap_taken <= take;
      if (halt_now) halted <= 1'b1;
      if (take) begin
        nia  <= VECTOR;
        srr0 <= cia;
        srr1 <= srr1_next;
        msr  <= msr_entry;
      end else if (retire) begin
        nia <= cia + XLEN'(4);
        if (msr_wr_en) msr <= msr_wr_val;
      end
    end
  end
endmodule

module prog_trap_unit_chk #(
  parameter int XLEN = 64,
  parameter logic [XLEN-1:0] VECTOR = 'h700,
  parameter int ILL_CAUSE = 44,
  parameter int PRIV_CAUSE = 45
) (
  input logic            clk,
  input logic            rst_n,
  input logic            insn_valid,
  input logic            cls_attn,
  input logic            insn_illegal,
  input logic [XLEN-1:0] cia,
  input logic [XLEN-1:0] nia,
  input logic [XLEN-1:0] msr,
  input logic [XLEN-1:0] srr0,
  input logic [XLEN-1:0] srr1,
  input logic            trap_taken,
  input logic            halted
);
  localparam int B_SF  = XLEN - 1 - 0;
  localparam int B_EE  = XLEN - 1 - 48;
  localparam int B_PR  = XLEN - 1 - 49;
  localparam int B_LE  = XLEN - 1 - 63;
  localparam logic [XLEN-1:0] CAUSES = (XLEN'(1) << (XLEN - 1 - ILL_CAUSE)) |
                                       (XLEN'(1) << (XLEN - 1 - PRIV_CAUSE));

  // R1
  vector_on_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |-> nia == VECTOR);

  // R4
  msr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |-> (msr[B_SF] && msr[B_LE] && !msr[B_PR] && !msr[B_EE]));

  // R2
  srr0_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |-> srr0 == $past(cia));

  // R3
  srr1_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |-> ((srr1 | CAUSES) == ($past(msr) | CAUSES)) &&
                   ($countones(srr1 & CAUSES) >= 1));

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R8
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(nia) && $stable(msr) && $stable(srr1) && !trap_taken));

  // R6
  super_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !halted && !msr[B_PR] && !insn_illegal) |=> !trap_taken);

  // R9
  idle_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> !trap_taken);
endmodule

bind prog_trap_unit prog_trap_unit_chk #(
  .XLEN(XLEN), .VECTOR(VECTOR), .ILL_CAUSE(ILL_CAUSE), .PRIV_CAUSE(PRIV_CAUSE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .cls_attn(cls_attn),
  .insn_illegal(insn_illegal), .cia(cia), .nia(nia), .msr(msr), .srr0(srr0),
  .srr1(srr1), .trap_taken(trap_taken), .halted(halted)
);

// File: tb/tb_prog_trap_unit.sv
module tb_prog_trap_unit;
  logic clk = 0, rst_n = 0;
  logic insn_valid = 0, cls_attn = 0, cls_msr_move = 0, cls_int_return = 0;
  logic cls_spr_move = 0, spr_num_hi = 0, insn_illegal = 0, msr_wr_en = 0;
  logic [63:0] cia = 0, msr_wr_val = 0;
  logic [63:0] nia, msr, srr0, srr1;
  logic trap_taken, halted;

  int checks = 0, fails = 0;
  logic [63:0] m_nia, m_msr, m_srr0, m_srr1;
  logic m_trap, m_halt;

  prog_trap_unit dut (.*);

  always #4 clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model: architectural bit n lives at index 63-n
  always @(posedge clk) begin
    logic user, privop, pfault;
    if (!rst_n) begin
      m_nia = 0; m_msr = 0; m_srr0 = 0; m_srr1 = 0; m_trap = 0; m_halt = 0;
    end else begin
      m_trap = 0;
      if (insn_valid && !m_halt) begin
        user   = m_msr[63-49];
        privop = cls_attn || cls_msr_move || cls_int_return || (cls_spr_move && spr_num_hi);
        pfault = privop && user;
        if (pfault || (!cls_attn && insn_illegal)) begin
          m_trap = 1;
          m_srr0 = cia;
          m_srr1 = m_msr;
          m_srr1[63 - (pfault ? 45 : 44)] = 1;
          m_msr[63-0] = 1; m_msr[63-63] = 1;
          m_msr[63-48] = 0; m_msr[63-49] = 0; m_msr[63-58] = 0;
          m_msr[63-59] = 0; m_msr[63-62] = 0;
          m_nia = 64'h700;
        end else if (cls_attn) begin
          m_halt = 1;
        end else begin
          m_nia = cia + 4;
          if (msr_wr_en) m_msr = msr_wr_val;
        end
      end
    end
    #2;
    chk("R1 nia", nia, m_nia);
    chk("R4 msr", msr, m_msr);
    chk("R2 srr0", srr0, m_srr0);
    chk("R3 srr1", srr1, m_srr1);
    chk("R9 trap_taken", 64'(trap_taken), 64'(m_trap));
    chk("R8 halted", 64'(halted), 64'(m_halt));
  end

  task automatic issue(logic a, logic mm, logic ir, logic sp, logic hi, logic il,
                       logic [63:0] addr, logic we, logic [63:0] wv);
    @(negedge clk);
    insn_valid = 1; cls_attn = a; cls_msr_move = mm; cls_int_return = ir;
    cls_spr_move = sp; spr_num_hi = hi; insn_illegal = il; cia = addr;
    msr_wr_en = we; msr_wr_val = wv;
    @(posedge clk); #3;
  endtask

  task automatic idle();
    @(negedge clk);
    insn_valid = 0; msr_wr_en = 0;
    @(posedge clk); #3;
  endtask

  localparam logic [63:0] PRBIT = 64'h4000;

  initial begin
    repeat (3) @(posedge clk);
    #3;
    // R11 reset state
    chk("R11 nia", nia, 0); chk("R11 msr", msr, 0); chk("R11 srr1", srr1, 0);
    chk("R11 trap", 64'(trap_taken), 0); chk("R11 halted", 64'(halted), 0);
    @(negedge clk); rst_n = 1;

    // R10 normal completion with state write (enter user state)
    issue(0,0,0,0,0,0, 64'h100, 1, PRBIT | 64'h3);
    chk("R10 msr load", msr, PRBIT | 64'h3);
    chk("R1 nia+4", nia, 64'h104);

    // R6 privileged MSR move in user state: trap, write dropped
    issue(0,1,0,0,0,0, 64'h1000, 1, 64'hFFFF);
    chk("R6 trap pulse", 64'(trap_taken), 1);
    chk("R2 srr0", srr0, 64'h1000);
    chk("R3 priv cause", srr1, PRBIT | 64'h3 | (64'h1 << 18));
    chk("R4 msr rewrite", msr, 64'h8000_0000_0000_0001);
    chk("R1 vector", nia, 64'h700);

    // R3 illegal in supervisor state
    issue(0,0,0,0,0,1, 64'h2000, 0, 0);
    chk("R3 ill cause", srr1, 64'h8000_0000_0000_0001 | (64'h1 << 19));
    idle();
    chk("R9 pulse ends", 64'(trap_taken), 0);

    // R5 spr move: hi clear does not trap, hi set does (user state)
    issue(0,0,0,0,0,0, 64'h300, 1, PRBIT);
    issue(0,0,0,1,0,0, 64'h304, 0, 0);
    chk("R5 spr lo no trap", 64'(trap_taken), 0);
    issue(0,0,0,1,1,0, 64'h308, 0, 0);
    chk("R5 spr hi trap", 64'(trap_taken), 1);

    // R7 privileged and illegal in user state -> privilege cause
    issue(0,0,0,0,0,0, 64'h400, 1, PRBIT);
    issue(0,0,1,0,0,1, 64'h404, 0, 0);
    chk("R7 priority", srr1, PRBIT | (64'h1 << 18));

    // R6 halt in user state traps instead of halting
    issue(0,0,0,0,0,0, 64'h500, 1, PRBIT);
    issue(1,0,0,0,0,0, 64'h504, 0, 0);
    chk("R6 attn user", 64'(halted), 0);

    // mixed random traffic without halts
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 5) == 0) idle();
      else issue(0, $urandom_range(0,7)==0, $urandom_range(0,9)==0,
                 $urandom_range(0,5)==0, 1'($urandom), $urandom_range(0,7)==0,
                 {$urandom, $urandom} & ~64'h3, 1'($urandom),
                 {$urandom, $urandom});
    end

    // R8 halt in supervisor state (with illegal set too), then ignored traffic
    issue(0,0,0,0,0,0, 64'h600, 1, 64'h0);
    issue(1,0,0,0,0,1, 64'h604, 0, 0);
    chk("R8 halted", 64'(halted), 1);
    chk("R8 nia held", nia, 64'h604);
    issue(0,0,0,0,0,1, 64'h608, 1, 64'hABCD);
    chk("R8 no trap", 64'(trap_taken), 0);
    chk("R8 msr held", msr, 0);
    chk("R8 nia still", nia, 64'h604);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule